// File: doc/BRIEF.md
# LCD-Shared General-Purpose I/O Port

This block is a seven-pin bidirectional I/O port slice for a microcontroller. A small register bus reaches four registers: a port view, an output latch, a direction register and a control register. For every pin, the block decides whether the pin is ordinary digital I/O or belongs to an LCD function. The LCD functions are the common drives, the bias supplies and one segment drive. From that decision it produces output-enable, output-data and weak pull-up enable for the pad ring.

Pin ownership is set by a 2-bit LCD multiplex setting, a bias-generation enable and a segment enable. These arrive as plain inputs. The LCD waveform generator lives elsewhere.

Pin 7 can also carry an alternate capture/compare output. That output has an optional open-drain drive mode. The peripheral's route, drive-enable and data lines are inputs.

Bit position 2 has no pin. It reads as zero everywhere.

Register map (2-bit `bus_addr`):

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | port view | updates the output latch | pad inputs |
| 1 | output latch | updates the output latch | latch contents |
| 2 | direction | 1 = input, 0 = output | direction bits |
| 3 | control | bit 0 = global pull-up enable, bit 1 = open-drain enable for the capture/compare output | the same two bits |

Top module: `lcd_gpio_port`

## Requirements
- R1: After reset:
  - reading address 2 returns 0xFB (every implemented pin is an input);
  - reading addresses 1 and 3 returns 0;
  - `pad_oe` is 0;
  - `pad_pu` is 0.
- R2: Bit 2 reads as 0 from every address, whatever was written. `pad_oe[2]`, `pad_do[2]`, `pad_pu[2]` and `pad_lcd_own[2]` are always 0.
- R3: On a pin owned by I/O, `pad_oe` is 1 exactly when its direction bit is 0. While `pad_oe` is 1, `pad_do` equals the latch bit; otherwise `pad_do` is 0.
- R4: A write to address 0 or to address 1 loads the output latch. Reading address 1 then returns the written value with bit 2 cleared, so writing 0 to either address clears the latch.
- R5: Reading address 0 returns `pad_di` for pins owned by I/O, and 0 for pins owned by an LCD function. The pad value is read through a synchronizer of `SYNC_STAGES` flops (default 2), so a change on `pad_di` shows up in the read after that many clock edges.
- R6: `pad_pu` is 1 on a pin only when all of these hold:
  - control bit 0 is set;
  - the pin is owned by I/O;
  - its direction bit is 1;
  - the pin is not being driven.
- R7: Bits 3, 4, 5 and 6 map to LCD commons 0 to 3. `lcd_mux` value m gives commons 0..m to the LCD:
  - 00 leaves bits 6, 5 and 4 for I/O;
  - 01 leaves bits 6 and 5;
  - 10 leaves bit 6 only;
  - 11 leaves none.
- R8: When `lcd_bias_en` is 1, bits 1 and 0 are owned by the LCD.
- R9: When `lcd_seg_en` is 1, bit 7 is owned by the LCD.
- R10: A pin owned by an LCD function shows `pad_lcd_own` = 1, and its `pad_oe`, `pad_do` and `pad_pu` are all 0, whatever the direction and latch bits hold.
- R11: With `cmp_route` = 1, bit 7 not owned by the LCD, and control bit 1 clear:
  - `pad_oe[7]` = `cmp_oe`;
  - `pad_do[7]` = `cmp_dout`.
- R12: With `cmp_route` = 1, bit 7 not owned by the LCD, and control bit 1 set, bit 7 is open-drain:
  - `pad_oe[7]` = `cmp_oe` & ~`cmp_dout`;
  - `pad_do[7]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| lcd_mux | input | 2 | LCD common multiplex setting |
| lcd_bias_en | input | 1 | LCD bias generation enable |
| lcd_seg_en | input | 1 | LCD segment enable for bit 7 |
| cmp_route | input | 1 | Capture/compare output routed to bit 7 |
| cmp_oe | input | 1 | Capture/compare drive enable |
| cmp_dout | input | 1 | Capture/compare output data |
| pad_di | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output data |
| pad_pu | output | 8 | Pad weak pull-up enable |
| pad_lcd_own | output | 8 | Pin handed to an LCD function |

## Verification
The ownership decode is tried with every value of the multiplex field. Bias and segment enable are each tried on and off. Together these separate which pin each common, the bias and the segment take.

Mixed direction and latch patterns, alternating and asymmetric, show that output enable and output data follow the right bit of the right register. Pull-up cases with the global bit set and cleared, on inputs and outputs, show that pull-ups are suppressed on driven pins.

The capture/compare tests drive both data values in push-pull and open-drain modes. They also let the segment enable take the pin away, which separates the three owners of bit 7.

// File: rtl/lcdgp_pkg.sv
package lcdgp_pkg;
   localparam int PORT_W = 8;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_PORT = 2'd0,
      REG_LAT  = 2'd1,
      REG_DIR  = 2'd2,
      REG_CTL  = 2'd3
   } reg_sel_e;

   localparam int CTL_PU_BIT = 0;
   localparam int CTL_OD_BIT = 1;
endpackage

// File: rtl/lcdgp_sync.sv
module lcdgp_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (STAGES < 1) $error("lcdgp_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain[s] <= '0;
            end else if (s == 0) begin
               chain[s] <= d;
            end else begin
               chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdgp_owner.sv
module lcdgp_owner #(
   parameter int          WIDTH     = 8,
   parameter logic [7:0]  IMPL_MASK = 8'hFB,
   parameter logic [7:0]  BIAS_MASK = 8'h03,
   parameter int          COM_BASE  = 3,
   parameter int          NUM_COM   = 4,
   parameter int          SEG_PIN   = 7,
   parameter int          MUX_W     = 2
) (
   input  logic [MUX_W-1:0] lcd_mux,
   input  logic             lcd_bias_en,
   input  logic             lcd_seg_en,
   output logic [WIDTH-1:0] lcd_own,
   output logic [WIDTH-1:0] io_own
);
   localparam int COM_TOP = COM_BASE + NUM_COM - 1;

   initial begin
      if (COM_TOP >= WIDTH) $error("lcdgp_owner: commons exceed port width");
      if (SEG_PIN >= WIDTH) $error("lcdgp_owner: segment pin out of range");
      if ((1 << MUX_W) < NUM_COM) $error("lcdgp_owner: multiplex field too narrow");
   end

   logic [WIDTH-1:0] raw_lcd;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         if (i >= COM_BASE && i <= COM_TOP) begin : g_com
            localparam int K = i - COM_BASE;
            assign raw_lcd[i] = (32'(lcd_mux) >= K);
         end else if (i == SEG_PIN) begin : g_seg
            assign raw_lcd[i] = lcd_seg_en;
         end else if (BIAS_MASK[i]) begin : g_bias
            assign raw_lcd[i] = lcd_bias_en;
         end else begin : g_plain
            assign raw_lcd[i] = 1'b0;
         end
      end
   endgenerate

   assign lcd_own = raw_lcd & IMPL_MASK[WIDTH-1:0];
   assign io_own  = ~raw_lcd & IMPL_MASK[WIDTH-1:0];
endmodule

// File: rtl/lcdgp_regs.sv
module lcdgp_regs
   import lcdgp_pkg::*;
#(
   parameter int         WIDTH     = 8,
   parameter logic [7:0] IMPL_MASK = 8'hFB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  pin_in,
   input  logic [WIDTH-1:0]  io_own,
   output logic [WIDTH-1:0]  lat_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic              pu_en,
   output logic              od_en,
   output logic [WIDTH-1:0]  rdata
);
   localparam logic [WIDTH-1:0] MASK = IMPL_MASK[WIDTH-1:0];

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= MASK;
         pu_en <= 1'b0;
         od_en <= 1'b0;
      end else if (we) begin
         unique case (sel)
            REG_PORT, REG_LAT: lat_q <= wdata & MASK;
            REG_DIR:           dir_q <= wdata & MASK;
            REG_CTL: begin
               pu_en <= wdata[CTL_PU_BIT];
               od_en <= wdata[CTL_OD_BIT];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         REG_PORT: rdata = pin_in & io_own & MASK;
         REG_LAT:  rdata = lat_q;
         REG_DIR:  rdata = dir_q;
         REG_CTL: begin
            rdata[CTL_PU_BIT] = pu_en;
            rdata[CTL_OD_BIT] = od_en;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/lcdgp_padctl.sv
module lcdgp_padctl #(
   parameter int WIDTH   = 8,
   parameter int CMP_PIN = 7
) (
   input  logic [WIDTH-1:0] io_own,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic             pu_en,
   input  logic             od_en,
   input  logic             cmp_route,
   input  logic             cmp_oe,
   input  logic             cmp_dout,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_do,
   output logic [WIDTH-1:0] pad_pu
);
   initial begin
      if (CMP_PIN >= WIDTH) $error("lcdgp_padctl: compare pin out of range");
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         logic oe_i, do_i;
         if (i == CMP_PIN) begin : g_cmp
            logic periph;
            assign periph = io_own[i] & cmp_route;
            always_comb begin
               if (periph) begin
                  oe_i = od_en ? (cmp_oe & ~cmp_dout) : cmp_oe;
                  do_i = od_en ? 1'b0 : (cmp_oe & cmp_dout);
               end else begin
                  oe_i = io_own[i] & ~dir_q[i];
                  do_i = io_own[i] & ~dir_q[i] & lat_q[i];
               end
            end
         end else begin : g_gpio
            assign oe_i = io_own[i] & ~dir_q[i];
            assign do_i = oe_i & lat_q[i];
         end
         assign pad_oe[i] = oe_i;
         assign pad_do[i] = do_i;
         assign pad_pu[i] = pu_en & io_own[i] & dir_q[i] & ~oe_i;
      end
   endgenerate
endmodule

// File: rtl/lcd_gpio_port.sv
module lcd_gpio_port
   import lcdgp_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] IMPL_MASK   = 8'hFB,
   parameter logic [7:0] BIAS_MASK   = 8'h03,
   parameter int         COM_BASE    = 3,
   parameter int         NUM_COM     = 4,
   parameter int         SEG_PIN     = 7,
   parameter int         CMP_PIN     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [1:0]        lcd_mux,
   input  logic              lcd_bias_en,
   input  logic              lcd_seg_en,
   input  logic              cmp_route,
   input  logic              cmp_oe,
   input  logic              cmp_dout,
   input  logic [PORT_W-1:0] pad_di,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_do,
   output logic [PORT_W-1:0] pad_pu,
   output logic [PORT_W-1:0] pad_lcd_own
);
   logic [PORT_W-1:0] io_own, lcd_own, pin_sync, lat_q, dir_q;
   logic              pu_en, od_en;

   lcdgp_owner #(
      .WIDTH(PORT_W), .IMPL_MASK(IMPL_MASK), .BIAS_MASK(BIAS_MASK),
      .COM_BASE(COM_BASE), .NUM_COM(NUM_COM), .SEG_PIN(SEG_PIN), .MUX_W(2)
   ) u_owner (
      .lcd_mux(lcd_mux), .lcd_bias_en(lcd_bias_en), .lcd_seg_en(lcd_seg_en),
      .lcd_own(lcd_own), .io_own(io_own)
   );

   lcdgp_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_di), .q(pin_sync)
   );

   lcdgp_regs #(.WIDTH(PORT_W), .IMPL_MASK(IMPL_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .pin_in(pin_sync), .io_own(io_own),
      .lat_q(lat_q), .dir_q(dir_q), .pu_en(pu_en), .od_en(od_en),
      .rdata(bus_rdata)
   );

   lcdgp_padctl #(.WIDTH(PORT_W), .CMP_PIN(CMP_PIN)) u_pad (
      .io_own(io_own), .lat_q(lat_q), .dir_q(dir_q), .pu_en(pu_en),
      .od_en(od_en), .cmp_route(cmp_route), .cmp_oe(cmp_oe),
      .cmp_dout(cmp_dout), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
   );

   assign pad_lcd_own = lcd_own;
endmodule

// File: rtl/lcd_gpio_port_chk.sv
module lcd_gpio_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_we,
   input logic [1:0] bus_addr,
   input logic [7:0] bus_wdata,
   input logic [7:0] lat_q,
   input logic       pu_en,
   input logic       od_en,
   input logic       cmp_route,
   input logic [7:0] pad_oe,
   input logic [7:0] pad_do,
   input logic [7:0] pad_pu,
   input logic [7:0] pad_lcd_own
);
   assert_lcd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_lcd_own & (pad_oe | pad_pu | pad_do)) == 8'h00);

   assert_no_pu_on_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == 8'h00);

   assert_pu_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu != 8'h00) |-> pu_en);

   assert_bit2_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[2] | pad_do[2] | pad_pu[2] | pad_lcd_own[2] | lat_q[2]) == 1'b0);

   assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=>
         (lat_q == ($past(bus_wdata) & 8'hFB)));

   assert_od_never_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_route && od_en && !pad_lcd_own[7]) |-> !pad_do[7]);
endmodule

bind lcd_gpio_port lcd_gpio_port_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .lat_q(lat_q), .pu_en(pu_en), .od_en(od_en),
   .cmp_route(cmp_route), .pad_oe(pad_oe), .pad_do(pad_do),
   .pad_pu(pad_pu), .pad_lcd_own(pad_lcd_own)
);

// File: tb/lcd_gpio_port_test.sv
module lcd_gpio_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [1:0] lcd_mux = 2'd0;
   logic       lcd_bias_en = 1'b0, lcd_seg_en = 1'b0;
   logic       cmp_route = 1'b0, cmp_oe = 1'b0, cmp_dout = 1'b0;
   logic [7:0] pad_di = 8'h00;
   logic [7:0] pad_oe, pad_do, pad_pu, pad_lcd_own;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lcd_gpio_port uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_mux(lcd_mux),
      .lcd_bias_en(lcd_bias_en), .lcd_seg_en(lcd_seg_en),
      .cmp_route(cmp_route), .cmp_oe(cmp_oe), .cmp_dout(cmp_dout),
      .pad_di(pad_di), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu),
      .pad_lcd_own(pad_lcd_own)
   );

   typedef struct packed {
      logic [1:0] mux;
      logic       bias;
      logic       seg;
      logic       via_lat;
      logic [7:0] dir;
      logic [7:0] lat;
      logic       pu;
      logic [7:0] di;
      logic [7:0] e_oe;
      logic [7:0] e_do;
      logic [7:0] e_pu;
      logic [7:0] e_own;
      logic [7:0] e_rd;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VECS [NVEC] = '{
      '{2'd0, 1'b0, 1'b0, 1'b0, 8'h03, 8'hA5, 1'b1, 8'hFF, 8'hF0, 8'hA0, 8'h03, 8'h08, 8'hF3},
      '{2'd1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h55, 8'hE0, 8'hE0, 8'h00, 8'h1B, 8'h40},
      '{2'd2, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b1, 8'hAA, 8'h00, 8'h00, 8'h43, 8'hB8, 8'h02},
      '{2'd3, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFB, 8'h00},
      '{2'd0, 1'b0, 1'b0, 1'b1, 8'h5A, 8'h3C, 1'b0, 8'h0F, 8'hA1, 8'h20, 8'h00, 8'h08, 8'h03},
      '{2'd1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h7E, 1'b1, 8'h00, 8'h62, 8'h62, 8'h81, 8'h18, 8'h00}
   };

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd2, r); check("R1", "dir after reset", r, 8'hFB);
      rd(2'd1, r); check("R1", "latch after reset", r, 8'h00);
      rd(2'd3, r); check("R1", "ctrl after reset", r, 8'h00);
      check("R1", "pad_oe after reset", pad_oe, 8'h00);
      check("R1", "pad_pu after reset", pad_pu, 8'h00);

      // table walk: R3 R5 R6 R7 R8 R9 R10
      for (int v = 0; v < NVEC; v++) begin
         lcd_mux = VECS[v].mux; lcd_bias_en = VECS[v].bias;
         lcd_seg_en = VECS[v].seg; pad_di = VECS[v].di;
         wr(2'd2, VECS[v].dir);
         wr(VECS[v].via_lat ? 2'd1 : 2'd0, VECS[v].lat);
         wr(2'd3, {7'd0, VECS[v].pu});
         repeat (3) @(negedge clk);
         #1;
         check("R3", $sformatf("vec%0d pad_oe", v), pad_oe, VECS[v].e_oe);
         check("R3", $sformatf("vec%0d pad_do", v), pad_do, VECS[v].e_do);
         check("R6", $sformatf("vec%0d pad_pu", v), pad_pu, VECS[v].e_pu);
         check("R7/R8/R9", $sformatf("vec%0d lcd_own", v), pad_lcd_own, VECS[v].e_own);
         rd(2'd0, r);
         check("R5", $sformatf("vec%0d port read", v), r, VECS[v].e_rd);
      end

      // R2 / R4 latch behaviour and bit 2
      lcd_mux = 2'd0; lcd_bias_en = 1'b0; lcd_seg_en = 1'b0;
      wr(2'd1, 8'hFF); rd(2'd1, r); check("R2", "latch bit2", r, 8'hFB);
      wr(2'd2, 8'h04); rd(2'd2, r); check("R2", "dir bit2", r, 8'h00);
      wr(2'd0, 8'h00); rd(2'd1, r); check("R4", "port write clears latch", r, 8'h00);
      wr(2'd0, 8'h96); rd(2'd1, r); check("R4", "port write loads latch", r, 8'h92);
      pad_di = 8'h04; repeat (3) @(negedge clk);
      rd(2'd0, r); check("R2", "port read bit2", r, 8'h00);

      // R5 synchronizer latency
      pad_di = 8'h00; repeat (3) @(negedge clk);
      pad_di = 8'h80;
      @(negedge clk); #1 bus_addr = 2'd0; #1 r = bus_rdata;
      check("R5", "one edge after change", r, 8'h00);
      @(negedge clk); #1 r = bus_rdata;
      check("R5", "two edges after change", r, 8'h80);

      // R11 push-pull capture/compare on bit 7
      wr(2'd2, 8'hFF); wr(2'd3, 8'h01);
      cmp_route = 1'b1; cmp_oe = 1'b1; cmp_dout = 1'b1; #1;
      check("R11", "pp oe7", {7'd0, pad_oe[7]}, 8'h01);
      check("R11", "pp do7", {7'd0, pad_do[7]}, 8'h01);
      cmp_dout = 1'b0; #1;
      check("R11", "pp low oe7", {7'd0, pad_oe[7]}, 8'h01);
      check("R11", "pp low do7", {7'd0, pad_do[7]}, 8'h00);

      // R12 open-drain
      wr(2'd3, 8'h03); #1;
      check("R12", "od low oe7", {7'd0, pad_oe[7]}, 8'h01);
      check("R12", "od low do7", {7'd0, pad_do[7]}, 8'h00);
      cmp_dout = 1'b1; #1;
      check("R12", "od high oe7", {7'd0, pad_oe[7]}, 8'h00);
      check("R12", "od high do7", {7'd0, pad_do[7]}, 8'h00);

      // R9 / R10 segment takes bit 7 from the peripheral
      cmp_dout = 1'b0; lcd_seg_en = 1'b1; #1;
      check("R9", "seg owns bit7", {7'd0, pad_lcd_own[7]}, 8'h01);
      check("R10", "seg quiets bit7", {6'd0, pad_oe[7], pad_pu[7]}, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule